// File: doc/BRIEF.md
# Near-Memory Atomic Reduction Unit

This block is a fixed-function read-modify-write engine that sits next to a cache or memory array. A requester offloads an atomic update by sending an opcode, a word address, a 32-bit operand and a tag. The unit reads the stored word, combines it with the operand, and writes the result back in place. It then returns only the tag, so the requester can free its pending-request slot. The requester never sees the old or the new value.

The four operations are increment by a delta, decrement by a delta, signed minimum and signed maximum. Requests to the same word are applied strictly in arrival order, one per cycle, and none is lost. An update that has just been written is forwarded straight into the next request, so no stall is needed. When the parameter `MARK_DIRTY` is set, for placement at a shared cache level, every update marks its line as modified. The cache's write-back path clears that mark with a clean strobe. With the parameter clear, for placement on the memory side, no line state is kept.

A registered look-up port lets the surrounding array logic read a word and its line's modified bit.

Top module: `atomicReduceUnit`

## Requirements
- R1: After reset, `respValid` is low, every word reads as zero on the look-up port, and no line is marked modified.
- R2: Opcode 0 adds the operand to the stored word, modulo 2^32.
- R3: Opcode 1 subtracts the operand from the stored word, modulo 2^32.
- R4: Opcode 2 stores the smaller of the stored word and the operand, with both taken as signed two's-complement values.
- R5: Opcode 3 stores the larger of the stored word and the operand, with both taken as signed two's-complement values.
- R6: Every request sampled with `reqValid` high gets exactly one `respValid` pulse two clock edges later. That pulse carries the request's tag, and responses come out in request order.
- R7: Requests to the same address on consecutive cycles each see the result of the one before, so no update is lost and arrival order is kept.
- R8: With `MARK_DIRTY` set, an update sets the modified bit of line `addr >> LINE_W` and leaves other lines untouched.
- R9: A clean strobe on a line clears its modified bit without changing its data. If an update writes the same line at the same edge, the bit stays set.
- R10: The look-up port returns the word and its line's modified bit one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Atomic request present this cycle |
| reqOp | input | 2 | Opcode: 0 add, 1 subtract, 2 signed min, 3 signed max |
| reqAddr | input | ADDR_W | Word address |
| reqOperand | input | 32 | Delta or comparison value |
| reqTag | input | TAG_W | Requester tag, returned on completion |
| respValid | output | 1 | Completion pulse |
| respTag | output | TAG_W | Tag of the completed request |
| cleanValid | input | 1 | Write-back done: clear a line's modified bit |
| cleanLine | input | ADDR_W-LINE_W | Line index to clean |
| lookAddr | input | ADDR_W | Look-up address |
| lookData | output | 32 | Word at lookAddr, one cycle later |
| lookDirty | output | 1 | Modified bit of lookAddr's line, one cycle later |

## Verification
The assertions assume that `rstN` is low for at least two edges with `reqValid` low. This keeps the two-edge history that the response checks use free of junk. They also assume that the request fields stay stable for the whole cycle in which `reqValid` is high. The bench drives every input on the falling edge and holds `reqValid` low during reset, so both assumptions hold. The look-up port is only sampled when no write to the same word is still pending. This respects the port's read-before-write timing.

// File: rtl/nmaPkg.sv
package nmaPkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MIN = 2'd2,
    OP_MAX = 2'd3
  } atomOp_e;

  // Strobes from control to datapath for the word being written this cycle
  typedef struct packed {
    logic    wrEn;
    logic    fwdSel;
    atomOp_e op;
  } ctrlStrobe_t;
endpackage

// File: rtl/nmaCtrl.sv
module nmaCtrl #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TAG_W-1:0]     reqTag,
  output nmaPkg::ctrlStrobe_t  strobe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic                 respValid,
  output logic [TAG_W-1:0]     respTag
);
  import nmaPkg::*;

  logic              s1Valid;
  atomOp_e           s1Op;
  logic [ADDR_W-1:0] s1Addr;
  logic [TAG_W-1:0]  s1Tag;
  logic              fwdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Op      <= OP_ADD;
      s1Addr    <= '0;
      s1Tag     <= '0;
      fwdHit    <= 1'b0;
      respValid <= 1'b0;
      respTag   <= '0;
    end else begin
      s1Valid <= reqValid;
      // the word being written at this edge is the one the new request needs
      fwdHit  <= reqValid && s1Valid && (s1Addr == reqAddr);
      if (reqValid) begin
        s1Op   <= atomOp_e'(reqOp);
        s1Addr <= reqAddr;
        s1Tag  <= reqTag;
      end
      respValid <= s1Valid;
      respTag   <= s1Tag;
    end
  end

  always_comb begin
    strobe.wrEn   = s1Valid;
    strobe.fwdSel = fwdHit;
    strobe.op     = s1Op;
    wrAddr        = s1Addr;
  end
endmodule

// File: rtl/nmaDatapath.sv
module nmaDatapath (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [nmaPkg::DATA_W-1:0]   reqOperand,
  input  nmaPkg::ctrlStrobe_t         strobe,
  input  logic [nmaPkg::DATA_W-1:0]   rdData,
  output logic [nmaPkg::DATA_W-1:0]   wrData
);
  import nmaPkg::*;

  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] fwdData;
  logic [DATA_W-1:0] oldVal;
  logic              opndLess;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opnd    <= '0;
      fwdData <= '0;
    end else begin
      if (reqValid) opnd <= reqOperand;
      fwdData <= wrData;
    end
  end

  always_comb begin
    oldVal   = strobe.fwdSel ? fwdData : rdData;
    opndLess = $signed(opnd) < $signed(oldVal);
    unique case (strobe.op)
      OP_ADD:  wrData = oldVal + opnd;
      OP_SUB:  wrData = oldVal - opnd;
      OP_MIN:  wrData = opndLess ? opnd : oldVal;
      default: wrData = opndLess ? oldVal : opnd;
    endcase
  end
endmodule

// File: rtl/nmaArray.sv
module nmaArray #(
  parameter int ADDR_W     = 6,
  parameter int LINE_W     = 2,
  parameter bit MARK_DIRTY = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [nmaPkg::DATA_W-1:0]   rdData,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [nmaPkg::DATA_W-1:0]   wrData,
  input  logic                        cleanValid,
  input  logic [ADDR_W-LINE_W-1:0]    cleanLine,
  input  logic [ADDR_W-1:0]           lookAddr,
  output logic [nmaPkg::DATA_W-1:0]   lookData,
  output logic                        lookDirty
);
  import nmaPkg::*;

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NLINES = 1 << (ADDR_W - LINE_W);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NLINES-1:0] dirty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData    <= '0;
      lookData  <= '0;
      lookDirty <= 1'b0;
    end else begin
      if (wrEn) mem[wrAddr] <= wrData;
      rdData    <= mem[rdAddr];
      lookData  <= mem[lookAddr];
      lookDirty <= dirty[lookAddr[ADDR_W-1:LINE_W]];
    end
  end

  generate
    if (MARK_DIRTY) begin : gDirty
      for (genvar l = 0; l < NLINES; l++) begin : gLine
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)
            dirty[l] <= 1'b0;
          else if (wrEn && (wrAddr[ADDR_W-1:LINE_W] == l))
            dirty[l] <= 1'b1;
          else if (cleanValid && (cleanLine == l))
            dirty[l] <= 1'b0;
        end
      end
    end else begin : gNoDirty
      assign dirty = '0;
    end
  endgenerate
endmodule

// File: rtl/atomicReduceUnit.sv
module atomicReduceUnit #(
  parameter int ADDR_W     = 6,
  parameter int LINE_W     = 2,
  parameter int TAG_W      = 4,
  parameter bit MARK_DIRTY = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqOp,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [31:0]              reqOperand,
  input  logic [TAG_W-1:0]         reqTag,
  output logic                     respValid,
  output logic [TAG_W-1:0]         respTag,
  input  logic                     cleanValid,
  input  logic [ADDR_W-LINE_W-1:0] cleanLine,
  input  logic [ADDR_W-1:0]        lookAddr,
  output logic [31:0]              lookData,
  output logic                     lookDirty
);
  import nmaPkg::*;

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;

  nmaCtrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqTag(reqTag), .strobe(strobe), .wrAddr(wrAddr),
    .respValid(respValid), .respTag(respTag)
  );

  nmaDatapath uDp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOperand(reqOperand),
    .strobe(strobe), .rdData(rdData), .wrData(wrData)
  );

  nmaArray #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .MARK_DIRTY(MARK_DIRTY)) uArr (
    .clk(clk), .rstN(rstN), .rdAddr(reqAddr), .rdData(rdData),
    .wrEn(strobe.wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cleanValid(cleanValid), .cleanLine(cleanLine),
    .lookAddr(lookAddr), .lookData(lookData), .lookDirty(lookDirty)
  );
endmodule

// File: rtl/atomicReduceChk.sv
module atomicReduceChk #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [31:0]       reqOperand,
  input logic [TAG_W-1:0]  reqTag,
  input logic              respValid,
  input logic [TAG_W-1:0]  respTag,
  input logic              wrEn,
  input logic [1:0]        wrOp,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##2 respValid); // R6
  AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid, 2)); // R6
  AST_RESP_TAG: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> respTag == $past(reqTag, 2)); // R6
  AST_ADD_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn) && wrAddr == $past(wrAddr) && wrOp == 2'd0)
      |-> wrData == $past(wrData) + $past(reqOperand)); // R7
  AST_SUB_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn) && wrAddr == $past(wrAddr) && wrOp == 2'd1)
      |-> wrData == $past(wrData) - $past(reqOperand)); // R3
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp == 2'd2) |-> $signed(wrData) <= $signed($past(reqOperand))); // R4
  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp == 2'd3) |-> $signed(wrData) >= $signed($past(reqOperand))); // R5
endmodule

bind atomicReduceUnit atomicReduceChk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOperand(reqOperand),
  .reqTag(reqTag), .respValid(respValid), .respTag(respTag),
  .wrEn(strobe.wrEn), .wrOp(strobe.op), .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/sim_atomicReduceUnit.sv
module sim_atomicReduceUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [5:0]  reqAddr = '0;
  logic [31:0] reqOperand = '0;
  logic [3:0]  reqTag = '0;
  logic        respValid;
  logic [3:0]  respTag;
  logic        cleanValid = 1'b0;
  logic [3:0]  cleanLine = '0;
  logic [5:0]  lookAddr = '0;
  logic [31:0] lookData;
  logic        lookDirty;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  atomicReduceUnit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqOperand(reqOperand), .reqTag(reqTag),
    .respValid(respValid), .respTag(respTag), .cleanValid(cleanValid),
    .cleanLine(cleanLine), .lookAddr(lookAddr), .lookData(lookData),
    .lookDirty(lookDirty)
  );

  // {op, addr, operand, expected word after the update}
  localparam logic [71:0] VEC [10] = '{
    {2'd0, 6'd5,  32'd10,         32'd10},
    {2'd1, 6'd5,  32'd3,          32'd7},
    {2'd3, 6'd5,  32'hFFFF_FFFC,  32'd7},
    {2'd2, 6'd5,  32'hFFFF_FFFC,  32'hFFFF_FFFC},
    {2'd0, 6'd9,  32'h7FFF_FFFF,  32'h7FFF_FFFF},
    {2'd0, 6'd9,  32'd1,          32'h8000_0000},
    {2'd3, 6'd9,  32'd5,          32'd5},
    {2'd1, 6'd12, 32'd1,          32'hFFFF_FFFF},
    {2'd2, 6'd12, 32'd2,          32'hFFFF_FFFF},
    {2'd3, 6'd12, 32'd0,          32'd0}
  };

  function automatic string opReq(input logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d, output logic dd);
    @(negedge clk);
    lookAddr = a;
    @(negedge clk);
    d  = lookData;
    dd = lookDirty;
  endtask

  task automatic drive(input logic [1:0] op, input logic [5:0] a,
                       input logic [31:0] v, input logic [3:0] t);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqOperand = v; reqTag = t;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic dd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(respValid == 1'b0, "R1", "respValid after reset", {31'd0, respValid}, 32'd0);
    peek(6'd5, d, dd);
    check(d == 32'd0, "R1", "word 5 after reset", d, 32'd0);
    check(dd == 1'b0, "R1", "line dirty after reset", {31'd0, dd}, 32'd0);
    peek(6'd63, d, dd);
    check(d == 32'd0, "R1", "word 63 after reset", d, 32'd0);

    // table walk: one request at a time, R2..R5 plus R6 and R10
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drive(VEC[i][71:70], VEC[i][69:64], VEC[i][63:32], 4'(i));
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      check(respValid == 1'b1, "R6", "response pulse", {31'd0, respValid}, 32'd1);
      check(respTag == 4'(i), "R6", "response tag", {28'd0, respTag}, 32'(i));
      peek(VEC[i][69:64], d, dd);
      check(d == VEC[i][31:0], opReq(VEC[i][71:70]), "stored word (R10 look-up)", d, VEC[i][31:0]);
    end

    // R8 line state
    peek(6'd5, d, dd);
    check(dd == 1'b1, "R8", "updated line marked", {31'd0, dd}, 32'd1);
    peek(6'd60, d, dd);
    check(dd == 1'b0, "R8", "untouched line clean", {31'd0, dd}, 32'd0);

    // R7 back-to-back burst of adds to word 20, with in-order R6 responses
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check(respValid == 1'b1, "R6", "burst response", {31'd0, respValid}, 32'd1);
        check(respTag == 4'(k + 6), "R6", "burst tag order", {28'd0, respTag}, 32'(k + 6));
      end
      if (k < 4) drive(2'd0, 6'd20, 32'(k + 1), 4'(k + 8));
      else reqValid = 1'b0;
    end
    peek(6'd20, d, dd);
    check(d == 32'd10, "R7", "burst sum", d, 32'd10);

    // R7 interleaved A,B,A
    @(negedge clk); drive(2'd0, 6'd30, 32'd5, 4'd1);
    @(negedge clk); drive(2'd0, 6'd31, 32'd7, 4'd2);
    @(negedge clk); drive(2'd0, 6'd30, 32'd1, 4'd3);
    @(negedge clk); reqValid = 1'b0;
    peek(6'd30, d, dd);
    check(d == 32'd6, "R7", "interleaved word A", d, 32'd6);
    peek(6'd31, d, dd);
    check(d == 32'd7, "R7", "interleaved word B", d, 32'd7);

    // R7 max then min back to back, R4/R5 on forwarded value
    @(negedge clk); drive(2'd3, 6'd40, 32'd100, 4'd4);
    @(negedge clk); drive(2'd2, 6'd40, 32'd50, 4'd5);
    @(negedge clk); reqValid = 1'b0;
    peek(6'd40, d, dd);
    check(d == 32'd50, "R7", "max then min chain", d, 32'd50);

    // R9 clean on its own
    @(negedge clk); cleanValid = 1'b1; cleanLine = 4'd1;
    @(negedge clk); cleanValid = 1'b0;
    peek(6'd5, d, dd);
    check(dd == 1'b0, "R9", "clean clears mark", {31'd0, dd}, 32'd0);
    check(d == 32'hFFFF_FFFC, "R9", "clean keeps data", d, 32'hFFFF_FFFC);

    // R9 clean coinciding with an update write on the same line
    @(negedge clk); cleanValid = 1'b1; cleanLine = 4'd2;
    @(negedge clk); cleanValid = 1'b0;
    peek(6'd9, d, dd);
    check(dd == 1'b0, "R9", "line 2 cleaned", {31'd0, dd}, 32'd0);
    @(negedge clk); drive(2'd0, 6'd9, 32'd0, 4'd6);
    @(negedge clk); reqValid = 1'b0; cleanValid = 1'b1; cleanLine = 4'd2;
    @(negedge clk); cleanValid = 1'b0;
    peek(6'd9, d, dd);
    check(dd == 1'b1, "R9", "update wins over clean", {31'd0, dd}, 32'd1);
    check(d == 32'd5, "R9", "data after update plus clean", d, 32'd5);

    summary();
    $finish;
  end
endmodule